// File: doc/BRIEF.md
# Platform-Level Interrupt Controller (single target)

This block gathers level-sensitive interrupt requests from a parameterised set of sources and delivers one machine external interrupt line to a single processor hart. Every source has its own pending bit and a small priority field. A two-word enable mask and one global threshold decide which pending sources may interrupt the hart.

Software reaches the block through a simple word-addressed register bus. A read of the claim register does three things in one step: it returns the ID of the best qualifying source, clears that source's pending bit and marks the source as in service. A source in service cannot become pending again. Software releases it by writing the same ID back to the claim register. With the default parameters there are 52 sources, 3-bit priorities and a 22-bit byte address.

Top module: `irq_ctrl`

## Requirements
- R1: Each source s (1..NSRC) has a 3-bit priority at byte offset 4*s, readable and writable in bits [2:0]. Offset 0 (ID 0) is reserved: it reads 0 and ignores writes.
- R2: The enable bits are at 0x2000 (word 0) and 0x2004 (word 1). Source s uses bit s%32 of word s/32. Bit 0 and bits for IDs above NSRC always read 0.
- R3: The pending bits read at 0x1000 and 0x1004 with the same bit layout as the enables, and writes there are ignored. A source's pending bit is set on the clock edge where its request is high and the source is neither pending nor in service. Request input bit i belongs to source i+1.
- R4: The threshold is a 3-bit register at 0x200000. A source qualifies only if it is pending, enabled and has a priority strictly above the threshold. Priority 0 therefore never qualifies, and a threshold of 7 masks everything.
- R5: A read of 0x200004 returns the qualifying source with the highest priority. On equal priority the lower ID wins.
- R6: A claim read with no qualifying source returns 0 and changes no state.
- R7: A claim read of a nonzero ID clears that source's pending bit and puts it in service. While it is in service, its request cannot set the pending bit again.
- R8: A write of an ID to 0x200004 takes that source out of service if it is in service. For any other ID the write is ignored.
- R9: The output eip is registered. It goes high on the clock edge after some source qualifies, and it goes low on the edge after none does.
- R10: Read data appears on bus_rdata with bus_rvalid high one cycle after the read request. Unmapped or misaligned addresses read 0.
- R11: Reset (synchronous, active high) clears every priority, enable, pending and in-service bit, the threshold and eip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NSRC | Level requests, bit i is source i+1 |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High one cycle after a read request |
| eip | output | 1 | Machine external interrupt toward the hart |

## Verification
The embedded assertions check on every cycle that the arbitration winner is pending, enabled and above the threshold. They also check that no source is pending and in service at once, that a claimed source's pending bit is cleared, that a source stays in service until completed, and that eip and rvalid follow their causes with one cycle of latency. Which source wins a tie, whether the enable and pending words pack their bits correctly, and whether stray or repeated completion writes really leave the state alone can only be shown by the bench's register-level scenarios.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned OFF_PEND = 32'h0000_1000;
  localparam int unsigned OFF_EN   = 32'h0000_2000;
  localparam int unsigned OFF_THR  = 32'h0020_0000;
  localparam int unsigned OFF_CLM  = 32'h0020_0004;
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway #(
  parameter int NSRC = 52
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC:1]   req,
  input  logic [NSRC:1]   claim_hit,
  input  logic [NSRC:1]   cmp_hit,
  output logic [NSRC:1]   pend,
  output logic [NSRC:1]   svc
);
  for (genvar s = 1; s <= NSRC; s++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[s] <= 1'b0;
        svc[s]  <= 1'b0;
      end else if (claim_hit[s]) begin
        pend[s] <= 1'b0;
        svc[s]  <= 1'b1;
      end else begin
        if (req[s] && !pend[s] && !svc[s]) pend[s] <= 1'b1;
        if (cmp_hit[s]) svc[s] <= 1'b0;
      end
    end

    // R7: a source is never pending while in service
    assert_pend_svc_excl_R7: assert property (@(posedge clk) disable iff (rst)
      !(pend[s] && svc[s]));

    // R8: service ends only through a completion for this source
    assert_svc_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      (svc[s] && !cmp_hit[s]) |=> svc[s]);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC   = 52,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NSRC:1]                pend,
  input  logic [NSRC:1]                en,
  input  logic [NSRC:1][PRIO_W-1:0]    prio,
  input  logic [PRIO_W-1:0]            thr,
  output logic [ID_W-1:0]              win_id,
  output logic                         win_valid
);
  logic [PRIO_W-1:0] best_p;

  // Strictly-greater compare keeps the lowest ID on ties
  always_comb begin
    best_p = thr;
    win_id = '0;
    for (int s = 1; s <= NSRC; s++) begin
      if (pend[s] && en[s] && (prio[s] > best_p)) begin
        best_p = prio[s];
        win_id = ID_W'(s);
      end
    end
  end

  assign win_valid = (win_id != '0);

  // R4: a winner always lies above the threshold
  assert_win_above_thr_R4: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (prio[win_id] > thr));

  // R5: a winner is always pending and enabled
  assert_win_live_R5: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (pend[win_id] && en[win_id]));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int NSRC   = 52,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 6,
  parameter int ADDR_W = 22
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_req,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [BUS_W-1:0]           bus_wdata,
  output logic [BUS_W-1:0]           bus_rdata,
  output logic                       bus_rvalid,
  input  logic [NSRC:1]              pend,
  input  logic [ID_W-1:0]            win_id,
  input  logic                       win_valid,
  output logic [NSRC:1][PRIO_W-1:0]  prio_q,
  output logic [NSRC:1]              en_q,
  output logic [PRIO_W-1:0]          thr_q,
  output logic [NSRC:1]              claim_hit,
  output logic [NSRC:1]              cmp_hit
);
  localparam int WA_W    = ADDR_W - 2;
  localparam int NWORD   = (NSRC + 1 + BUS_W - 1) / BUS_W;
  localparam int VEC_W   = NWORD * BUS_W;
  localparam int PEND_WA = OFF_PEND / 4;
  localparam int EN_WA   = OFF_EN / 4;
  localparam int THR_WA  = OFF_THR / 4;
  localparam int CLM_WA  = OFF_CLM / 4;

  logic [WA_W-1:0]  wa;
  logic             aligned, rd_go, wr_go, claim_rd, claim_wr;
  logic [VEC_W-1:0] pend_vec, en_vec;
  logic [BUS_W-1:0] rd_mux;

  assign wa       = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign rd_go    = bus_req && !bus_we && aligned;
  assign wr_go    = bus_req && bus_we && aligned;
  assign claim_rd = rd_go && (wa == WA_W'(CLM_WA));
  assign claim_wr = wr_go && (wa == WA_W'(CLM_WA));

  for (genvar s = 1; s <= NSRC; s++) begin : g_hit
    assign claim_hit[s] = claim_rd && (win_id == ID_W'(s));
    assign cmp_hit[s]   = claim_wr && (bus_wdata == BUS_W'(s));
  end

  always_comb begin
    pend_vec = '0;
    en_vec   = '0;
    for (int s = 1; s <= NSRC; s++) begin
      pend_vec[s] = pend[s];
      en_vec[s]   = en_q[s];
    end
  end

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (wr_go) begin
      for (int s = 1; s <= NSRC; s++) begin
        if (wa == WA_W'(s)) prio_q[s] <= bus_wdata[PRIO_W-1:0];
        if (wa == WA_W'(EN_WA + s / BUS_W)) en_q[s] <= bus_wdata[s % BUS_W];
      end
      if (wa == WA_W'(THR_WA)) thr_q <= bus_wdata[PRIO_W-1:0];
    end
  end

  // Read decode
  always_comb begin
    rd_mux = '0;
    for (int s = 1; s <= NSRC; s++)
      if (wa == WA_W'(s)) rd_mux = BUS_W'(prio_q[s]);
    for (int w = 0; w < NWORD; w++) begin
      if (wa == WA_W'(PEND_WA + w)) rd_mux = pend_vec[w*BUS_W +: BUS_W];
      if (wa == WA_W'(EN_WA + w))   rd_mux = en_vec[w*BUS_W +: BUS_W];
    end
    if (wa == WA_W'(THR_WA)) rd_mux = BUS_W'(thr_q);
    if (wa == WA_W'(CLM_WA)) rd_mux = BUS_W'(win_id);
    if (!aligned) rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_req && !bus_we;
      bus_rdata  <= (bus_req && !bus_we) ? rd_mux : '0;
    end
  end

  // R7: the claimed source's pending bit is gone one cycle later
  assert_claim_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (claim_rd && win_valid) |=> !pend_vec[$past(win_id)]);

  // R10: every read request is answered on the next cycle
  assert_rvalid_next_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> bus_rvalid);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int NSRC   = 52,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 22
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    irq_src,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               bus_rvalid,
  output logic               eip
);
  localparam int ID_W = $clog2(NSRC + 1);

  logic [NSRC:1]             req_v, pend, svc, en_q, claim_hit, cmp_hit;
  logic [NSRC:1][PRIO_W-1:0] prio_q;
  logic [PRIO_W-1:0]         thr_q;
  logic [ID_W-1:0]           win_id;
  logic                      win_valid;

  assign req_v = irq_src;

  irq_gateway #(.NSRC(NSRC)) u_gw (
    .clk(clk), .rst(rst), .req(req_v), .claim_hit(claim_hit),
    .cmp_hit(cmp_hit), .pend(pend), .svc(svc)
  );

  irq_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .clk(clk), .rst(rst), .pend(pend), .en(en_q), .prio(prio_q),
    .thr(thr_q), .win_id(win_id), .win_valid(win_valid)
  );

  irq_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pend(pend), .win_id(win_id),
    .win_valid(win_valid), .prio_q(prio_q), .en_q(en_q), .thr_q(thr_q),
    .claim_hit(claim_hit), .cmp_hit(cmp_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) eip <= 1'b0;
    else     eip <= win_valid;
  end

  // R9: eip follows qualification with one register of latency
  assert_eip_rise_R9: assert property (@(posedge clk) disable iff (rst)
    win_valid |=> eip);
  assert_eip_fall_R9: assert property (@(posedge clk) disable iff (rst)
    !win_valid |=> !eip);
endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  localparam int NSRC = 52;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_SRC = 3'd2,
                         OP_EIP = 3'd3, OP_IDLE = 3'd4;
  localparam logic [21:0] A_P0 = 22'h1000, A_P1 = 22'h1004, A_E0 = 22'h2000,
                          A_E1 = 22'h2004, A_THR = 22'h200000, A_CLM = 22'h200004;

  typedef struct packed {
    logic [2:0]  op;
    logic [21:0] addr;
    logic [63:0] data;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    '{OP_WR,  22'h014, 64'd3, 32'd0, 4'd1},
    '{OP_RD,  22'h014, 64'd0, 32'd3, 4'd1},            // R1
    '{OP_WR,  22'h0A0, 64'd3, 32'd0, 4'd1},
    '{OP_WR,  22'h024, 64'd6, 32'd0, 4'd1},
    '{OP_WR,  22'h000, 64'd5, 32'd0, 4'd1},
    '{OP_RD,  22'h000, 64'd0, 32'd0, 4'd1},            // R1 reserved ID
    '{OP_WR,  A_E0, 64'hFFFF_FFFF, 32'd0, 4'd2},
    '{OP_RD,  A_E0, 64'd0, 32'hFFFF_FFFE, 4'd2},       // R2
    '{OP_WR,  A_E1, 64'hFFFF_FFFF, 32'd0, 4'd2},
    '{OP_RD,  A_E1, 64'd0, 32'h001F_FFFF, 4'd2},       // R2
    '{OP_RD,  A_CLM, 64'd0, 32'd0, 4'd6},              // R6
    '{OP_EIP, 22'h0, 64'd0, 32'd0, 4'd9},              // R9
    '{OP_SRC, 22'h0, (64'd1<<4)|(64'd1<<8)|(64'd1<<39), 32'd0, 4'd3},
    '{OP_EIP, 22'h0, 64'd0, 32'd1, 4'd9},              // R9
    '{OP_RD,  A_P0, 64'd0, 32'h220, 4'd3},             // R3
    '{OP_RD,  A_P1, 64'd0, 32'h100, 4'd3},             // R3
    '{OP_RD,  A_CLM, 64'd0, 32'd9, 4'd5},              // R5
    '{OP_RD,  A_CLM, 64'd0, 32'd5, 4'd5},              // R5 tie
    '{OP_RD,  A_P0, 64'd0, 32'd0, 4'd7},               // R7
    '{OP_RD,  A_CLM, 64'd0, 32'd40, 4'd5},
    '{OP_RD,  A_CLM, 64'd0, 32'd0, 4'd6},              // R6
    '{OP_EIP, 22'h0, 64'd0, 32'd0, 4'd9},
    '{OP_WR,  A_CLM, 64'd40, 32'd0, 4'd8},
    '{OP_IDLE,22'h0, 64'd0, 32'd0, 4'd8},
    '{OP_RD,  A_P1, 64'd0, 32'h100, 4'd8},             // R8
    '{OP_WR,  A_THR, 64'd3, 32'd0, 4'd4},
    '{OP_RD,  A_CLM, 64'd0, 32'd0, 4'd4},              // R4
    '{OP_RD,  A_THR, 64'd0, 32'd3, 4'd4},
    '{OP_WR,  A_THR, 64'd2, 32'd0, 4'd4},
    '{OP_RD,  A_CLM, 64'd0, 32'd40, 4'd4}              // R4
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [NSRC-1:0] irq_src = '0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [21:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, eip;
  int checks = 0, failures = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  irq_ctrl dut (
    .clk(clk), .rst(rst), .irq_src(irq_src), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .eip(eip)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [21:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rdv(input logic [21:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check("R11 eip", {31'd0, eip}, 32'd0);
    check("R11 rdata", bus_rdata, 32'd0);
    rdv(22'h024, rd); check("R11 prio", rd, 32'd0);
    rdv(A_E0, rd);    check("R11 enable", rd, 32'd0);
    rdv(A_THR, rd);   check("R11 thr", rd, 32'd0);

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        OP_WR:  wr(TBL[i].addr, TBL[i].data[31:0]);
        OP_RD: begin
          rdv(TBL[i].addr, rd);
          check($sformatf("R%0d row %0d", TBL[i].rq, i), rd, TBL[i].exp);
        end
        OP_SRC: begin
          irq_src = TBL[i].data[NSRC-1:0];
          @(negedge clk);
        end
        OP_EIP: begin
          @(negedge clk);
          check($sformatf("R%0d eip row %0d", TBL[i].rq, i), {31'd0, eip}, TBL[i].exp);
        end
        default: @(negedge clk);
      endcase
    end

    // R8: completion releases a source; stray completions are ignored
    irq_src = '0; @(negedge clk);
    wr(A_CLM, 32'd5); @(negedge clk);
    rdv(A_P0, rd); check("R8 req low no pend", rd, 32'd0);
    irq_src = (52'd1 << 4) | (52'd1 << 8); @(negedge clk);
    rdv(A_P0, rd); check("R7 svc blocks src9", rd, 32'h20);
    wr(A_CLM, 32'd9); @(negedge clk);
    rdv(A_P0, rd); check("R8 src9 re-pends", rd, 32'h220);
    wr(A_CLM, 32'd9); wr(A_CLM, 32'd0); wr(A_CLM, 32'd60);
    rdv(A_CLM, rd); check("R8 stray completes ignored", rd, 32'd9);
    wr(A_CLM, 32'd9); @(negedge clk);
    // R3: pending words ignore writes
    wr(A_P0, 32'hFFFF_FFFF);
    rdv(A_P0, rd); check("R3 pend write ignored", rd, 32'h220);

    // R4: threshold 7 masks everything, even priority 7
    wr(22'h024, 32'd7); wr(A_THR, 32'd7); @(negedge clk); @(negedge clk);
    check("R4 eip masked", {31'd0, eip}, 32'd0);
    rdv(A_CLM, rd); check("R4 claim masked", rd, 32'd0);
    wr(A_THR, 32'd0);
    check("R9 eip latency", {31'd0, eip}, 32'd0);
    @(negedge clk);
    check("R9 eip raised", {31'd0, eip}, 32'd1);
    rdv(A_CLM, rd); check("R5 highest prio", rd, 32'd9);
    rdv(A_CLM, rd); check("R5 next", rd, 32'd5);
    rdv(A_CLM, rd); check("R6 empty", rd, 32'd0);

    // R10: read timing and unmapped addresses
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 22'h3000;
    @(negedge clk);
    check("R10 rvalid", {31'd0, bus_rvalid}, 32'd1);
    check("R10 unmapped", bus_rdata, 32'd0);
    bus_req = 1'b0;
    rdv(22'h015, rd); check("R10 misaligned", rd, 32'd0);

    // R11: reset mid-run
    rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0;
    check("R11 eip after reset", {31'd0, eip}, 32'd0);
    rdv(A_E1, rd); check("R11 enable cleared", rd, 32'd0);
    rdv(A_CLM, rd); check("R11 claim cleared", rd, 32'd0);

    finish_run();
  end
endmodule